// File: doc/BRIEF.md
# Flash Erase Command Interpreter

This block sits on the device side of a parallel NOR-style flash array and interprets write strobes, each carrying an address and a data byte. It recognises two six-write erase commands. Chip erase selects every sector and starts erasing at once. Sector erase opens an acceptance window. While that window is open, further sector-erase writes add sectors to a one-hot erase bitmap and restart the window. A write carrying any other command cancels the whole request.

When the window expires, the abstracted erase phase runs. It is a cycle counter that, on completion, marks the selected sectors in an erased-sector map. While a sector erase is running, it can be suspended and later resumed. A chip erase ignores every write. An asynchronous hardware reset aborts any erase at once.

Two outputs report status. A ready/busy line is low while the block is occupied. A timer-status bit is low during the acceptance window and high once erasure has begun.

Top module: `flash_erase_ctl`

## Requirements
- R1: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55 followed by 0x10 at address 0x555 start a chip erase on the clock edge of the sixth write: `erase_sel` becomes all ones, `ready` goes to 0 and `timer_done` goes to 1.
- R2: The same five writes followed by data 0x30 at any address open the acceptance window on the edge of the sixth write. The sector index is taken from `wr_addr[ADDR_W-1 -: log2(NUM_SECT)]` (bits 11:9 at the defaults). `erase_sel` holds exactly that one bit, and `ready` and `timer_done` are both 0.
- R3: The window stays open for WINDOW_CYC cycles after the last accepted write. Each 0x30 write inside the window ORs its sector into `erase_sel` and restarts the window, including a write on the very edge where the window would have expired.
- R4: A write inside the window whose data is neither 0x30 nor 0xB0 returns the block to read mode on that edge. `ready` becomes 1, `erase_sel` becomes 0, and no sector is ever erased from that request.
- R5: `timer_done` is 0 in read mode and in the window. It is 1 from the edge on which erasure starts until erasure ends, including while suspended.
- R6: Erasure lasts ERASE_CYC active cycles. On the final edge, `erased_map` gains the bits of `erase_sel`, `erase_sel` clears, and `ready` returns to 1. Bits of `erased_map` are never cleared except by reset.
- R7: During a sector erase, data 0xB0 suspends it: `suspended` is 1, `ready` is 1, `timer_done` is 1, and the remaining count is frozen. While suspended, only data 0x30 is honoured; it resumes the erase with the frozen count. All other writes are ignored.
- R8: During a chip erase, every write is ignored, including 0xB0, and the erase completes ERASE_CYC cycles after it started.
- R9: A low `rst_n` aborts any erase at once. Afterwards `ready` is 1, `timer_done` is 0, `suspended` is 0, and `erase_sel` and `erased_map` are 0; nothing is marked erased later.
- R10: A wrong address or data byte on any of the first five writes returns the decoder to idle, so the writes that follow that command's pattern start no erase.
- R11: A 0xB0 write inside the window neither aborts the request nor restarts the window, and it leaves `erase_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; a write is taken on the rising edge while `wr_en` is high |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address; upper bits select the sector |
| wr_data | input | 8 | Command byte |
| ready | output | 1 | High in read mode and while suspended, low in the window and during erasure |
| timer_done | output | 1 | 0 in the window, 1 once erasure has started |
| suspended | output | 1 | High while a sector erase is suspended |
| erase_sel | output | NUM_SECT | One-hot bitmap of the sectors queued for erasure |
| erased_map | output | NUM_SECT | Sectors marked erased since reset |

## Verification
The bench corrupts each of the five preamble writes in turn. A decoder that does not fall back to idle would launch a chip erase from the writes that follow. It sends a queueing write exactly on the expiry edge; a design that lets expiry win would erase too early and drop the last sector. Suspend is placed mid-erase, and completion is checked to the exact cycle. This catches a counter that keeps running or reloads on resume. It also checks that a suspend byte is ignored during chip erase and during the window, where a wrong design would either restart the window or abort the request.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_WINDOW = 2'd1,
    MODE_ERASE  = 2'd2,
    MODE_SUSP   = 2'd3
  } fe_mode_e;

  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [11:0] ADDR_CMD   = 12'h555;

  // Address (upper 12 bits) and data (lower 8 bits) expected on preamble step 0..4
  function automatic logic [19:0] preamble_pair(input logic [2:0] step);
    case (step)
      3'd0:    preamble_pair = {12'h555, 8'hAA};
      3'd1:    preamble_pair = {12'h2AA, 8'h55};
      3'd2:    preamble_pair = {12'h555, 8'h80};
      3'd3:    preamble_pair = {12'h555, 8'hAA};
      default: preamble_pair = {12'h2AA, 8'h55};
    endcase
  endfunction

endpackage

// File: rtl/fe_preamble_dec.sv
module fe_preamble_dec
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              chip_go,
  output logic              sect_go,
  output logic [SECT_W-1:0] sect_idx
);
  localparam logic [2:0] LAST_STEP = 3'd5;

  logic [2:0]  step_q;
  logic [19:0] want;
  logic        step_hit;
  logic        at_final;

  always_comb begin
    want     = preamble_pair(step_q);
    step_hit = wr_en && (step_q != LAST_STEP) &&
               (wr_addr == ADDR_W'(want[19:8])) && (wr_data == want[7:0]);
    at_final = enable && wr_en && (step_q == LAST_STEP);
    chip_go  = at_final && (wr_addr == ADDR_W'(ADDR_CMD)) && (wr_data == CMD_CHIP);
    sect_go  = at_final && (wr_data == CMD_SECTOR);
    sect_idx = wr_addr[ADDR_W-1 -: SECT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          step_q <= 3'd0;
    else if (!enable)    step_q <= 3'd0;
    else if (wr_en)      step_q <= step_hit ? step_q + 3'd1 : 3'd0;
  end
endmodule

// File: rtl/fe_countdown.sv
module fe_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= load_val;
    else if (run && (cnt_q != '0))     cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_SECT   = 8,
  parameter int WINDOW_CYC = 1000,
  parameter int ERASE_CYC  = 5000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output logic                ready,
  output logic                timer_done,
  output logic                suspended,
  output logic [NUM_SECT-1:0] erase_sel,
  output logic [NUM_SECT-1:0] erased_map
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
  localparam int ERS_W  = $clog2(ERASE_CYC + 1);

  fe_mode_e            mode_q;
  logic                chip_q;
  logic [NUM_SECT-1:0] sel_q, map_q;

  logic              chip_go, sect_go;
  logic [SECT_W-1:0] sect_idx, wr_idx;
  logic              win_last, ers_last;

  // Named internal events, also observed by the checker
  logic in_window, in_erase, chip_mode;
  logic is_sect_wr, is_susp_wr;
  logic accept_wr, abort_wr, win_expire;
  logic suspend_wr, resume_wr, erase_done;

  assign wr_idx     = wr_addr[ADDR_W-1 -: SECT_W];
  assign in_window  = (mode_q == MODE_WINDOW);
  assign in_erase   = (mode_q == MODE_ERASE);
  assign chip_mode  = chip_q;
  assign is_sect_wr = wr_en && (wr_data == CMD_SECTOR);
  assign is_susp_wr = wr_en && (wr_data == CMD_SUSPEND);
  assign accept_wr  = in_window && is_sect_wr;
  assign abort_wr   = in_window && wr_en && !is_sect_wr && !is_susp_wr;
  assign win_expire = in_window && win_last && !accept_wr && !abort_wr;
  assign suspend_wr = in_erase && !chip_q && is_susp_wr;
  assign resume_wr  = (mode_q == MODE_SUSP) && is_sect_wr;
  assign erase_done = in_erase && ers_last && !suspend_wr;

  fe_preamble_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (mode_q == MODE_READ),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .chip_go (chip_go),
    .sect_go (sect_go),
    .sect_idx(sect_idx)
  );

  fe_countdown #(.CNT_W(WIN_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sect_go || accept_wr),
    .load_val(WIN_W'(WINDOW_CYC)),
    .run     (in_window),
    .last    (win_last)
  );

  fe_countdown #(.CNT_W(ERS_W)) u_ers (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (chip_go || win_expire),
    .load_val(ERS_W'(ERASE_CYC)),
    .run     (in_erase && !suspend_wr),
    .last    (ers_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_READ;
      chip_q <= 1'b0;
      sel_q  <= '0;
      map_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_READ: begin
          if (chip_go) begin
            mode_q <= MODE_ERASE;
            chip_q <= 1'b1;
            sel_q  <= '1;
          end else if (sect_go) begin
            mode_q <= MODE_WINDOW;
            chip_q <= 1'b0;
            sel_q  <= NUM_SECT'(1) << sect_idx;
          end
        end
        MODE_WINDOW: begin
          if (abort_wr) begin
            mode_q <= MODE_READ;
            sel_q  <= '0;
          end else if (accept_wr) begin
            sel_q  <= sel_q | (NUM_SECT'(1) << wr_idx);
          end else if (win_expire) begin
            mode_q <= MODE_ERASE;
          end
        end
        MODE_ERASE: begin
          if (suspend_wr) begin
            mode_q <= MODE_SUSP;
          end else if (erase_done) begin
            mode_q <= MODE_READ;
            map_q  <= map_q | sel_q;
            sel_q  <= '0;
            chip_q <= 1'b0;
          end
        end
        default: begin
          if (resume_wr) mode_q <= MODE_ERASE;
        end
      endcase
    end
  end

  assign ready      = (mode_q == MODE_READ) || (mode_q == MODE_SUSP);
  assign timer_done = (mode_q == MODE_ERASE) || (mode_q == MODE_SUSP);
  assign suspended  = (mode_q == MODE_SUSP);
  assign erase_sel  = sel_q;
  assign erased_map = map_q;
endmodule

// File: rtl/fe_erase_chk.sv
module fe_erase_chk #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                ready,
  input logic                timer_done,
  input logic                suspended,
  input logic [NUM_SECT-1:0] erase_sel,
  input logic [NUM_SECT-1:0] erased_map,
  input logic                in_window,
  input logic                chip_mode,
  input logic                accept_wr,
  input logic                abort_wr
);
  p_window_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_window) |-> ($countones(erase_sel) == 1));

  p_accept_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr |=> (in_window && ((erase_sel & $past(erase_sel)) == $past(erase_sel))));

  p_abort_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (ready && (erase_sel == '0) && !in_window));

  p_window_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (!timer_done && !ready));

  p_busy_has_work_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (erase_sel != '0));

  p_map_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((erased_map & $past(erased_map)) == $past(erased_map)));

  p_suspend_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (ready && timer_done && (erase_sel != '0)));

  p_chip_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_mode && !ready && wr_en) |=> !suspended);
endmodule

bind flash_erase_ctl fe_erase_chk #(.NUM_SECT(NUM_SECT)) u_fe_erase_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .ready     (ready),
  .timer_done(timer_done),
  .suspended (suspended),
  .erase_sel (erase_sel),
  .erased_map(erased_map),
  .in_window (in_window),
  .chip_mode (chip_mode),
  .accept_wr (accept_wr),
  .abort_wr  (abort_wr)
);

// File: tb/test_flash_erase_ctl.sv
module test_flash_erase_ctl;
  localparam int AW = 12;
  localparam int NS = 8;
  localparam int W  = 10;
  localparam int E  = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          ready, timer_done, suspended;
  logic [NS-1:0] erase_sel, erased_map;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_erase_ctl #(.ADDR_W(AW), .NUM_SECT(NS), .WINDOW_CYC(W), .ERASE_CYC(E)) i_flash_erase_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready(ready), .timer_done(timer_done), .suspended(suspended),
    .erase_sel(erase_sel), .erased_map(erased_map)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preamble();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  function automatic logic [AW-1:0] sect_addr(input int i);
    return AW'(i * 512 + 'h0A7);
  endfunction

  task automatic hw_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    logic [NS-1:0] exp_map;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // Reset state
    check("R9 reset ready", ready, 1);
    check("R5 reset timer_done", timer_done, 0);
    check("R9 reset sel", erase_sel, 0);
    check("R9 reset map", erased_map, 0);
    check("R9 reset suspended", suspended, 0);

    // R9: reset during chip erase
    preamble(); wr(12'h555, 8'h10);
    check("R1 chip sel", erase_sel, 8'hFF);
    check("R1 chip busy", ready, 0);
    check("R1 chip timer_done", timer_done, 1);
    idle(5);
    hw_reset();
    check("R9 abort ready", ready, 1);
    check("R9 abort sel", erase_sel, 0);
    check("R9 abort timer_done", timer_done, 0);
    idle(E + W);
    check("R9 nothing erased later", erased_map, 0);

    // R10: corrupt each preamble step
    for (int pos = 0; pos < 5; pos++) begin
      logic [19:0] seq [5];
      seq[0] = {12'h555, 8'hAA}; seq[1] = {12'h2AA, 8'h55}; seq[2] = {12'h555, 8'h80};
      seq[3] = {12'h555, 8'hAA}; seq[4] = {12'h2AA, 8'h55};
      for (int k = 0; k < 5; k++) begin
        if (k == pos) wr(seq[k][19:8], seq[k][7:0] ^ 8'hFF);
        else          wr(seq[k][19:8], seq[k][7:0]);
      end
      wr(12'h555, 8'h10);
      check($sformatf("R10 corrupt step %0d ready", pos), ready, 1);
      check($sformatf("R10 corrupt step %0d sel", pos), erase_sel, 0);
      idle(3);
    end

    // R1/R8: chip erase ignores writes
    preamble(); wr(12'h555, 8'h10);
    check("R1 chip start", {ready, timer_done}, 2'b01);
    idle(5);
    wr(12'h000, 8'hB0);
    check("R8 suspend ignored", suspended, 0);
    wr(12'h000, 8'hF0);
    check("R8 other write ignored", ready, 0);
    idle(E - 8);
    check("R6 chip still busy", ready, 0);
    idle(1);
    check("R6 chip done ready", ready, 1);
    check("R1 chip map", erased_map, 8'hFF);
    check("R6 chip sel cleared", erase_sel, 0);

    // R2/R3/R5/R6: each sector alone
    hw_reset();
    exp_map = '0;
    for (int i = 0; i < NS; i++) begin
      preamble(); wr(sect_addr(i), 8'h30);
      check($sformatf("R2 sector %0d sel", i), erase_sel, 1 << i);
      check($sformatf("R2 sector %0d status", i), {ready, timer_done}, 2'b00);
      idle(W - 1);
      check($sformatf("R3 sector %0d window open", i), {ready, timer_done}, 2'b00);
      idle(1);
      check($sformatf("R5 sector %0d erasing", i), {ready, timer_done}, 2'b01);
      idle(E - 1);
      check($sformatf("R6 sector %0d busy", i), ready, 0);
      idle(1);
      exp_map = exp_map | NS'(1 << i);
      check($sformatf("R6 sector %0d map", i), erased_map, exp_map);
      check($sformatf("R5 sector %0d timer_done low", i), timer_done, 0);
    end

    // R3: several sectors, one queued on the expiry edge
    hw_reset();
    preamble(); wr(sect_addr(7), 8'h30);
    idle(3);
    wr(sect_addr(2), 8'h30);
    idle(W - 1);
    wr(sect_addr(5), 8'h30);
    check("R3 queued sel", erase_sel, 8'hA4);
    check("R3 window restarted", {ready, timer_done}, 2'b00);
    idle(W - 1);
    check("R3 window still open", timer_done, 0);
    idle(1);
    check("R3 erase started", timer_done, 1);
    idle(E);
    check("R3 multi map", erased_map, 8'hA4);

    // R11: suspend byte inside window; then R7 suspend/resume
    preamble(); wr(sect_addr(1), 8'h30);
    idle(2);
    wr(12'h000, 8'hB0);
    check("R11 sel unchanged", erase_sel, 8'h02);
    check("R11 window kept", {ready, timer_done}, 2'b00);
    idle(W - 4);
    check("R11 not restarted yet open", timer_done, 0);
    idle(1);
    check("R11 expiry on time", {ready, timer_done}, 2'b01);
    idle(3);
    wr(12'h000, 8'hB0);
    check("R7 suspended", {suspended, ready, timer_done}, 3'b111);
    wr(12'h000, 8'hF0);
    check("R7 ignored while suspended", suspended, 1);
    idle(20);
    check("R7 frozen map", erased_map, 8'hA4);
    wr(12'h000, 8'h30);
    check("R7 resumed", {suspended, ready}, 2'b00);
    idle(E - 3 - 1);
    check("R7 remaining count busy", ready, 0);
    idle(1);
    check("R7 done ready", ready, 1);
    check("R7 map after resume", erased_map, 8'hA6);

    // R4: abort inside window
    preamble(); wr(sect_addr(3), 8'h30);
    idle(2);
    wr(sect_addr(6), 8'h30);
    wr(12'h123, 8'hF0);
    check("R4 abort ready", ready, 1);
    check("R4 abort sel", erase_sel, 0);
    check("R4 abort timer_done", timer_done, 0);
    idle(W + E);
    check("R4 nothing erased", erased_map, 8'hA6);

    summary();
  end
endmodule